// File: doc/BRIEF.md
# Configuration Memory Page Programmer

This controller sits on top of a two-wire bus master engine and moves whole pages between an internal byte buffer and a serial configuration memory. A request names an operation and a page index. The controller then walks the engine through its command sequence: a start condition, three address bytes, the page data and a stop condition. The address bytes go out most significant bit first. Data bytes go out least significant bit first. It asserts a serial-enable output for as long as the memory has to stay in programming mode.

A page write is followed by acknowledge polling. The controller repeats a short start, address byte and stop probe until the memory acknowledges, which means its internal program cycle has ended. If the poll window runs out first, the request ends with a timeout error. Two further operations handle the four reset-polarity bytes at the top of the address space. One programs them from the first four buffer bytes. The other reads them back and compares them against those buffer bytes. Every request ends with a one-cycle done pulse and a 2-bit status code.

Top module: `cfgPageProg`

## Requirements
- R1: After reset, reqReady is 1 and serEn, engCmdValid and doneP are 0.
- R2: A page write (reqOp=1) issues, in order: START (engCmd=0); three SEND (engCmd=1) commands carrying the byte address reqPage*PAGE_BYTES, bits 23:16 first, then 15:8, then 7:0, with engLsbFirst=0; PAGE_BYTES SEND commands carrying buffer bytes 0 upward with engLsbFirst=1; and STOP (engCmd=3).
- R3: After the write's STOP, the controller repeats the probe START, SEND of address bits 23:16, STOP. It stops after the first probe whose SEND is acknowledged and then reports status 0.
- R4: If a probe SEND is not acknowledged once POLL_LIMIT_CYCLES cycles have elapsed since polling began, the controller finishes that probe's STOP and reports status 2, the timeout code.
- R5: A not-acknowledge on any address or data SEND of a write goes straight to STOP. The request then reports status 1 and issues no probes.
- R6: A page read (reqOp=0) issues START, the three address SENDs, PAGE_BYTES RECV commands (engCmd=2) and STOP. engLastRead is 1 only on the final RECV. The received bytes land in buffer indices 0 upward and can be read on bufRdData after done, with status 0.
- R7: Polarity program (reqOp=2) writes buffer bytes 0..3 to byte address 0x020000 using the R2 framing with 4 data bytes. It then polls as in R3.
- R8: Polarity verify (reqOp=3) reads 4 bytes from address 0x020000. It reports status 3 if any byte differs from buffer bytes 0..3 and status 0 otherwise. The buffer is left unchanged.
- R9: serEn is 1 from the cycle after a request is accepted through the done cycle, and 0 whenever the controller is idle. The engine sees commands only while serEn is 1.
- R10: A request is accepted only when reqValid and reqReady are both 1. reqValid raised while a request is in progress has no effect on the command stream or the status.
- R11: doneP lasts exactly one cycle, and reqReady is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | 0 read page, 1 write page, 2 polarity program, 3 polarity verify |
| reqPage | input | PAGE_IDX_W | Page index |
| reqReady | output | 1 | Controller idle, request can be taken |
| doneP | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 no-ack, 2 poll timeout, 3 verify mismatch |
| serEn | output | 1 | Serial programming mode enable to the memory |
| bufWrEn | input | 1 | Host buffer write strobe (honoured while idle) |
| bufWrAddr | input | $clog2(PAGE_BYTES) | Host buffer write index |
| bufWrData | input | 8 | Host buffer write data |
| bufRdAddr | input | $clog2(PAGE_BYTES) | Host buffer read index |
| bufRdData | output | 8 | Buffer byte at bufRdAddr |
| engCmdValid | output | 1 | Command held to the bus engine until engDone |
| engCmd | output | 2 | 0 start, 1 send byte, 2 receive byte, 3 stop |
| engTxByte | output | 8 | Byte to send |
| engLsbFirst | output | 1 | Send least significant bit first |
| engLastRead | output | 1 | Receive is the last byte of the stream |
| engDone | input | 1 | Engine finished the current command |
| engAck | input | 1 | Send was acknowledged (valid with engDone) |
| engRxByte | input | 8 | Received byte (valid with engDone) |

## Verification
Writes are swept over every page index of a small configuration. Each write uses a different count of not-acknowledged probes, which separates address arithmetic errors from poll loop errors. A second sweep drops the acknowledge at each address and data position in turn, which pins down exactly where the write aborts. Reads cover every page with page-specific data, so the order of stored bytes and the position of the last-byte flag are both checked. Polarity verify is run with a clean readback and with a single corrupted byte at each of the four positions, which shows the compare covers every byte and never alters the buffer.

// File: rtl/cfgPageProgPkg.sv
package cfgPageProgPkg;

  localparam logic [1:0] OP_READ       = 2'd0;
  localparam logic [1:0] OP_WRITE      = 2'd1;
  localparam logic [1:0] OP_POL_PROG   = 2'd2;
  localparam logic [1:0] OP_POL_VERIFY = 2'd3;

  localparam logic [1:0] CMD_START = 2'd0;
  localparam logic [1:0] CMD_SEND  = 2'd1;
  localparam logic [1:0] CMD_RECV  = 2'd2;
  localparam logic [1:0] CMD_STOP  = 2'd3;

  localparam logic [1:0] ST_OK       = 2'd0;
  localparam logic [1:0] ST_NACK     = 2'd1;
  localparam logic [1:0] ST_TIMEOUT  = 2'd2;
  localparam logic [1:0] ST_MISMATCH = 2'd3;

  localparam logic [23:0] POLARITY_ADDR = 24'h020000;

  typedef enum logic [3:0] {
    IDLE, S_START, S_ADDR, S_WDATA, S_RDATA, S_STOP,
    P_START, P_ADDR, P_STOP, FIN
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic clrIdx;
    logic incIdx;
    logic rxStrobe;
    logic setNack;
    logic setTimeout;
    logic clrPoll;
    logic setPollHit;
    logic selData;
  } ctrl_t;

endpackage

// File: rtl/cfgPageData.sv
module cfgPageData
  import cfgPageProgPkg::*;
#(
  parameter int PAGE_BYTES        = 128,
  parameter int PAGE_IDX_W        = 10,
  parameter int POLL_LIMIT_CYCLES = 2500000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_t                 ctl,
  input  logic [1:0]            reqOp,
  input  logic [PAGE_IDX_W-1:0] reqPage,
  input  logic                  hostWrEn,
  input  logic [$clog2(PAGE_BYTES)-1:0] hostWrAddr,
  input  logic [7:0]            hostWrData,
  input  logic [$clog2(PAGE_BYTES)-1:0] hostRdAddr,
  output logic [7:0]            hostRdData,
  input  logic [7:0]            engRxByte,
  output logic [7:0]            engTxByte,
  output logic                  lastAddr,
  output logic                  lastData,
  output logic                  writeOp,
  output logic                  errSeen,
  output logic                  timedOut,
  output logic                  pollHit,
  output logic [1:0]            status
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int TMR_W = $clog2(POLL_LIMIT_CYCLES + 1);

  logic [7:0]            mem [PAGE_BYTES];
  logic [1:0]            opReg;
  logic [PAGE_IDX_W-1:0] pageReg;
  logic [IDX_W-1:0]      idx;
  logic [TMR_W-1:0]      pollTmr;
  logic [23:0]           byteAddr;
  logic [7:0]            addrByte;
  logic [7:0]            curByte;
  logic                  isPol;

  assign isPol    = opReg[1];
  assign writeOp  = (opReg == OP_WRITE) || (opReg == OP_POL_PROG);
  assign byteAddr = isPol ? POLARITY_ADDR : (24'(pageReg) << IDX_W);
  assign curByte  = mem[idx];
  assign lastAddr = (idx == IDX_W'(2));
  assign lastData = isPol ? (idx == IDX_W'(3)) : (idx == IDX_W'(PAGE_BYTES - 1));
  assign errSeen  = (status != ST_OK);
  assign timedOut = (pollTmr == TMR_W'(POLL_LIMIT_CYCLES));
  assign hostRdData = mem[hostRdAddr];

  always_comb begin
    case (idx[1:0])
      2'd0:    addrByte = byteAddr[23:16];
      2'd1:    addrByte = byteAddr[15:8];
      default: addrByte = byteAddr[7:0];
    endcase
  end
  assign engTxByte = ctl.selData ? curByte : addrByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= OP_READ;
      pageReg <= '0;
      idx     <= '0;
      pollTmr <= '0;
      pollHit <= 1'b0;
      status  <= ST_OK;
    end else begin
      if (ctl.loadReq) begin
        opReg   <= reqOp;
        pageReg <= reqPage;
        status  <= ST_OK;
      end
      if (ctl.clrIdx)      idx <= '0;
      else if (ctl.incIdx) idx <= idx + 1'b1;

      if (ctl.clrPoll) begin
        pollTmr <= '0;
        pollHit <= 1'b0;
      end else begin
        if (!timedOut)      pollTmr <= pollTmr + 1'b1;
        if (ctl.setPollHit) pollHit <= 1'b1;
      end

      if (status == ST_OK) begin
        if (ctl.setNack)         status <= ST_NACK;
        else if (ctl.setTimeout) status <= ST_TIMEOUT;
        else if (ctl.rxStrobe && opReg == OP_POL_VERIFY && engRxByte != curByte)
          status <= ST_MISMATCH;
      end
    end
  end

  // buffer: received page data has priority over the host port
  always_ff @(posedge clk) begin
    if (ctl.rxStrobe && opReg == OP_READ) mem[idx] <= engRxByte;
    else if (hostWrEn)                    mem[hostWrAddr] <= hostWrData;
  end

endmodule

// File: rtl/cfgPageCtrl.sv
module cfgPageCtrl
  import cfgPageProgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqFire,
  input  logic       engDone,
  input  logic       engAck,
  input  logic       lastAddr,
  input  logic       lastData,
  input  logic       writeOp,
  input  logic       errSeen,
  input  logic       timedOut,
  input  logic       pollHit,
  output ctrl_t      ctl,
  output logic       idle,
  output logic       doneP,
  output logic       serEn,
  output logic       engCmdValid,
  output logic [1:0] engCmd,
  output logic       engLsbFirst,
  output logic       engLastRead
);
  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      IDLE: if (reqFire) begin
        ctl.loadReq = 1'b1;
        ctl.clrIdx  = 1'b1;
        nxt = S_START;
      end
      S_START: if (engDone) nxt = S_ADDR;
      S_ADDR: if (engDone) begin
        if (!engAck) begin
          ctl.setNack = 1'b1;
          nxt = S_STOP;
        end else if (lastAddr) begin
          ctl.clrIdx = 1'b1;
          nxt = writeOp ? S_WDATA : S_RDATA;
        end else ctl.incIdx = 1'b1;
      end
      S_WDATA: begin
        ctl.selData = 1'b1;
        if (engDone) begin
          if (!engAck) begin
            ctl.setNack = 1'b1;
            nxt = S_STOP;
          end else if (lastData) nxt = S_STOP;
          else ctl.incIdx = 1'b1;
        end
      end
      S_RDATA: if (engDone) begin
        ctl.rxStrobe = 1'b1;
        if (lastData) nxt = S_STOP;
        else ctl.incIdx = 1'b1;
      end
      S_STOP: if (engDone) begin
        if (writeOp && !errSeen) begin
          ctl.clrPoll = 1'b1;
          ctl.clrIdx  = 1'b1;
          nxt = P_START;
        end else nxt = FIN;
      end
      P_START: if (engDone) nxt = P_ADDR;
      P_ADDR: if (engDone) begin
        if (engAck)        ctl.setPollHit = 1'b1;
        else if (timedOut) ctl.setTimeout = 1'b1;
        nxt = P_STOP;
      end
      P_STOP: if (engDone) nxt = (pollHit || errSeen) ? FIN : P_START;
      FIN: nxt = IDLE;
      default: nxt = IDLE;
    endcase
  end

  always_comb begin
    case (state)
      S_START, P_START:        engCmd = CMD_START;
      S_ADDR, S_WDATA, P_ADDR: engCmd = CMD_SEND;
      S_RDATA:                 engCmd = CMD_RECV;
      default:                 engCmd = CMD_STOP;
    endcase
  end

  assign idle        = (state == IDLE);
  assign doneP       = (state == FIN);
  assign serEn       = (state != IDLE);
  assign engCmdValid = (state != IDLE) && (state != FIN);
  assign engLsbFirst = (state == S_WDATA);
  assign engLastRead = (state == S_RDATA) && lastData;

endmodule

// File: rtl/cfgPageProg.sv
module cfgPageProg
  import cfgPageProgPkg::*;
#(
  parameter int PAGE_BYTES        = 128,
  parameter int PAGE_IDX_W        = 10,
  parameter int POLL_LIMIT_CYCLES = 2500000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqOp,
  input  logic [PAGE_IDX_W-1:0] reqPage,
  output logic                  reqReady,
  output logic                  doneP,
  output logic [1:0]            status,
  output logic                  serEn,
  input  logic                  bufWrEn,
  input  logic [$clog2(PAGE_BYTES)-1:0] bufWrAddr,
  input  logic [7:0]            bufWrData,
  input  logic [$clog2(PAGE_BYTES)-1:0] bufRdAddr,
  output logic [7:0]            bufRdData,
  output logic                  engCmdValid,
  output logic [1:0]            engCmd,
  output logic [7:0]            engTxByte,
  output logic                  engLsbFirst,
  output logic                  engLastRead,
  input  logic                  engDone,
  input  logic                  engAck,
  input  logic [7:0]            engRxByte
);
  ctrl_t ctl;
  logic  lastAddr, lastData, writeOp, errSeen, timedOut, pollHit;

  cfgPageCtrl ctrlI (
    .clk(clk), .rstN(rstN), .reqFire(reqValid && reqReady),
    .engDone(engDone), .engAck(engAck),
    .lastAddr(lastAddr), .lastData(lastData), .writeOp(writeOp),
    .errSeen(errSeen), .timedOut(timedOut), .pollHit(pollHit),
    .ctl(ctl), .idle(reqReady), .doneP(doneP), .serEn(serEn),
    .engCmdValid(engCmdValid), .engCmd(engCmd),
    .engLsbFirst(engLsbFirst), .engLastRead(engLastRead)
  );

  cfgPageData #(
    .PAGE_BYTES(PAGE_BYTES), .PAGE_IDX_W(PAGE_IDX_W),
    .POLL_LIMIT_CYCLES(POLL_LIMIT_CYCLES)
  ) dataI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqOp(reqOp), .reqPage(reqPage),
    .hostWrEn(bufWrEn && reqReady), .hostWrAddr(bufWrAddr),
    .hostWrData(bufWrData), .hostRdAddr(bufRdAddr), .hostRdData(bufRdData),
    .engRxByte(engRxByte), .engTxByte(engTxByte),
    .lastAddr(lastAddr), .lastData(lastData), .writeOp(writeOp),
    .errSeen(errSeen), .timedOut(timedOut), .pollHit(pollHit),
    .status(status)
  );

endmodule

// File: rtl/cfgPageProgChk.sv
module cfgPageProgChk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       doneP,
  input logic       serEn,
  input logic       engCmdValid,
  input logic       engDone,
  input logic [1:0] engCmd,
  input logic [7:0] engTxByte
);
  assert_cmd_only_enabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    engCmdValid |-> serEn);

  assert_busy_enabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> serEn);

  assert_accept_goes_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> (!doneP && reqReady));

  assert_cmd_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (engCmdValid && !engDone) |=> (engCmdValid && $stable(engCmd) && $stable(engTxByte)));
endmodule

bind cfgPageProg cfgPageProgChk chkI (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .doneP(doneP), .serEn(serEn), .engCmdValid(engCmdValid),
  .engDone(engDone), .engCmd(engCmd), .engTxByte(engTxByte)
);

// File: tb/cfgPageProg_test.sv
`timescale 1ns/1ps
module cfgPageProg_test;
  localparam int PB    = 8;
  localparam int PIW   = 4;
  localparam int LIMIT = 40;
  localparam int IW    = $clog2(PB);

  logic clk = 0, rstN = 0;
  logic reqValid = 0;
  logic [1:0] reqOp = 0;
  logic [PIW-1:0] reqPage = 0;
  logic reqReady, doneP, serEn;
  logic [1:0] status;
  logic bufWrEn = 0;
  logic [IW-1:0] bufWrAddr = 0, bufRdAddr = 0;
  logic [7:0] bufWrData = 0, bufRdData;
  logic engCmdValid, engLsbFirst, engLastRead;
  logic [1:0] engCmd;
  logic [7:0] engTxByte;
  logic engDone = 0, engAck = 0;
  logic [7:0] engRxByte = 0;

  always #4 clk = ~clk;

  cfgPageProg #(.PAGE_BYTES(PB), .PAGE_IDX_W(PIW), .POLL_LIMIT_CYCLES(LIMIT)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqPage(reqPage),
    .reqReady(reqReady), .doneP(doneP), .status(status), .serEn(serEn),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .bufRdAddr(bufRdAddr), .bufRdData(bufRdData),
    .engCmdValid(engCmdValid), .engCmd(engCmd), .engTxByte(engTxByte),
    .engLsbFirst(engLsbFirst), .engLastRead(engLastRead),
    .engDone(engDone), .engAck(engAck), .engRxByte(engRxByte)
  );

  int checks = 0, failures = 0;
  logic [7:0] expBuf [PB];

  // engine model state and command log
  int logN = 0, sendIdx = 0, stopsSeen = 0, rxIdx = 0;
  int nackSendIdx = -1, pollNackLeft = 0, flipIdx = -1, rxSeed = 0;
  bit rxFromBuf = 0;
  int logCmd [256], logByte [256], logLsb [256], logLast [256];
  int expCmd [256], expByte [256], expLsb [256], expLast [256];
  int expN = 0;
  logic [1:0] lastStatus;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rxVal(input int i);
    logic [7:0] v;
    v = rxFromBuf ? expBuf[i] : 8'((i * 37 + rxSeed) & 255);
    if (i == flipIdx) v = v ^ 8'h5A;
    return v;
  endfunction

  initial begin : engine
    int c; bit a; logic [7:0] r;
    forever begin
      @(negedge clk);
      if (rstN && engCmdValid && !engDone) begin
        c = int'(engCmd); a = 1'b1; r = 8'h00;
        if (logN < 256) begin
          logCmd[logN] = c;
          logByte[logN] = (c == 1) ? int'(engTxByte) : 0;
          logLsb[logN] = (c == 1) ? int'(engLsbFirst) : 0;
          logLast[logN] = (c == 2) ? int'(engLastRead) : 0;
        end
        logN++;
        if (c == 1) begin
          if (stopsSeen == 0) begin
            a = (sendIdx != nackSendIdx);
            sendIdx++;
          end else begin
            a = (pollNackLeft == 0);
            if (pollNackLeft > 0) pollNackLeft--;
          end
        end else if (c == 2) begin
          r = rxVal(rxIdx);
          rxIdx++;
        end else if (c == 3) stopsSeen++;
        @(negedge clk);
        engDone = 1'b1; engAck = a; engRxByte = r;
        @(negedge clk);
        engDone = 1'b0;
      end
    end
  end

  task automatic pushExp(input int c, input int b, input int l, input int last);
    expCmd[expN] = c; expByte[expN] = b; expLsb[expN] = l; expLast[expN] = last;
    expN++;
  endtask

  task automatic pushAddr(input int addr);
    for (int a = 0; a < 3; a++) pushExp(1, (addr >> (8 * (2 - a))) & 255, 0, 0);
  endtask

  task automatic pushPolls(input int addr, input int n);
    for (int p = 0; p < n; p++) begin
      pushExp(0, 0, 0, 0); pushExp(1, (addr >> 16) & 255, 0, 0); pushExp(3, 0, 0, 0);
    end
  endtask

  task automatic compareLog(input string req);
    int bad;
    bad = -1;
    chk(logN == expN, req, logN, expN);
    for (int i = 0; i < expN && i < logN && i < 256; i++)
      if (bad < 0 && (logCmd[i] != expCmd[i] || logByte[i] != expByte[i] ||
                      logLsb[i] != expLsb[i] || logLast[i] != expLast[i])) bad = i;
    if (bad >= 0)
      chk(0, req, logCmd[bad] * 1000 + logByte[bad], expCmd[bad] * 1000 + expByte[bad]);
    else chk(1, req, 0, 0);
  endtask

  task automatic loadBuf(input int seed);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      bufWrEn = 1; bufWrAddr = IW'(i); bufWrData = 8'((i * 11 + seed) & 255);
      expBuf[i] = bufWrData;
    end
    @(negedge clk); bufWrEn = 0;
  endtask

  task automatic runReq(input logic [1:0] op, input int page, input bit noisy);
    int w;
    logN = 0; sendIdx = 0; stopsSeen = 0; rxIdx = 0; expN = 0;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 ready before request", reqReady, 1);
    reqValid = 1; reqOp = op; reqPage = PIW'(page);
    @(negedge clk);
    chk(serEn == 1'b1, "R9 enable after accept", serEn, 1);
    if (noisy) begin
      reqOp = 2'd0; reqPage = '1;
      repeat (20) @(negedge clk);
    end
    reqValid = 0;
    w = 0;
    while (!doneP && w < 4000) begin @(negedge clk); w++; end
    chk(doneP == 1'b1, "R11 done reached", doneP, 1);
    chk(serEn == 1'b1, "R9 enable in done cycle", serEn, 1);
    lastStatus = status;
    @(negedge clk);
    chk(!doneP && reqReady && !serEn, "R11 done one cycle then idle R9",
        {doneP, reqReady, serEn}, 3'b010);
  endtask

  task automatic checkBufRead(input string req);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk); bufRdAddr = IW'(i); #1;
      chk(bufRdData == expBuf[i], req, bufRdData, expBuf[i]);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady == 1 && serEn == 0 && engCmdValid == 0 && doneP == 0,
        "R1 reset state", {reqReady, serEn, engCmdValid, doneP}, 4'b1000);
    rstN = 1;
    @(negedge clk);

    // R2, R3: write every page, probe count varies
    for (int p = 0; p < 16; p++) begin
      loadBuf(p * 5);
      nackSendIdx = -1; pollNackLeft = p % 4;
      runReq(2'd1, p, 1'b0);
      chk(lastStatus == 2'd0, "R3 write status ok", lastStatus, 0);
      pushExp(0, 0, 0, 0); pushAddr(p * PB);
      for (int d = 0; d < PB; d++) pushExp(1, expBuf[d], 1, 0);
      pushExp(3, 0, 0, 0); pushPolls(p * PB, (p % 4) + 1);
      compareLog("R2 R3 write frame and polling");
    end

    // R6: read every page
    for (int p = 0; p < 16; p++) begin
      rxFromBuf = 0; flipIdx = -1; rxSeed = p * 3 + 1;
      runReq(2'd0, p, 1'b0);
      chk(lastStatus == 2'd0, "R6 read status ok", lastStatus, 0);
      pushExp(0, 0, 0, 0); pushAddr(p * PB);
      for (int d = 0; d < PB; d++) pushExp(2, 0, 0, (d == PB - 1) ? 1 : 0);
      pushExp(3, 0, 0, 0);
      compareLog("R6 read frame");
      for (int d = 0; d < PB; d++) expBuf[d] = rxVal(d);
      checkBufRead("R6 read data stored");
    end

    // R5: not-acknowledge at each address and data position
    loadBuf(77);
    for (int k = 0; k < 3 + PB; k++) begin
      nackSendIdx = k; pollNackLeft = 0;
      runReq(2'd1, 5, 1'b0);
      chk(lastStatus == 2'd1, "R5 nack status", lastStatus, 1);
      pushExp(0, 0, 0, 0);
      for (int s = 0; s <= k; s++)
        if (s < 3) pushExp(1, ((5 * PB) >> (8 * (2 - s))) & 255, 0, 0);
        else pushExp(1, expBuf[s - 3], 1, 0);
      pushExp(3, 0, 0, 0);
      compareLog("R5 abort after nack");
    end
    nackSendIdx = -1;

    // R4: poll timeout
    pollNackLeft = 100000;
    runReq(2'd1, 9, 1'b0);
    chk(lastStatus == 2'd2, "R4 timeout status", lastStatus, 2);
    chk(logN >= 5 + PB + 6, "R4 several probes before timeout", logN, 5 + PB + 6);
    pushExp(0, 0, 0, 0); pushAddr(9 * PB);
    for (int d = 0; d < PB; d++) pushExp(1, expBuf[d], 1, 0);
    pushExp(3, 0, 0, 0); pushPolls(9 * PB, (logN - (5 + PB)) / 3);
    compareLog("R4 probe frames until timeout");
    pollNackLeft = 0;

    // R10: request noise while busy
    loadBuf(200);
    runReq(2'd1, 3, 1'b1);
    chk(lastStatus == 2'd0, "R10 status unaffected", lastStatus, 0);
    pushExp(0, 0, 0, 0); pushAddr(3 * PB);
    for (int d = 0; d < PB; d++) pushExp(1, expBuf[d], 1, 0);
    pushExp(3, 0, 0, 0); pushPolls(3 * PB, 1);
    compareLog("R10 frame unaffected by busy request");

    // R7: polarity program
    loadBuf(33);
    pollNackLeft = 2;
    runReq(2'd2, 0, 1'b0);
    chk(lastStatus == 2'd0, "R7 polarity program status", lastStatus, 0);
    pushExp(0, 0, 0, 0); pushAddr(32'h20000);
    for (int d = 0; d < 4; d++) pushExp(1, expBuf[d], 1, 0);
    pushExp(3, 0, 0, 0); pushPolls(32'h20000, 3);
    compareLog("R7 polarity program frame");

    // R8: polarity verify, clean and one bad byte at each position
    for (int f = -1; f < 4; f++) begin
      loadBuf(90 + f);
      rxFromBuf = 1; flipIdx = f;
      runReq(2'd3, 7, 1'b0);
      chk(lastStatus == ((f < 0) ? 2'd0 : 2'd3), "R8 verify status", lastStatus,
          (f < 0) ? 0 : 3);
      pushExp(0, 0, 0, 0); pushAddr(32'h20000);
      for (int d = 0; d < 4; d++) pushExp(2, 0, 0, (d == 3) ? 1 : 0);
      pushExp(3, 0, 0, 0);
      compareLog("R8 verify frame");
      checkBufRead("R8 buffer unchanged");
    end
    rxFromBuf = 0; flipIdx = -1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule